// File: doc/BRIEF.md
# Multi-Channel Serial Frame Collector

The block listens to a one-way three-wire serial link (data, active-low select and bit clock) that arrives with no timing relationship to the local system clock. The three wires first pass through a two-flop synchronizer. The bit clock is then handled as an ordinary data signal: its rising edges are found in the system clock domain, and each edge that occurs while select is low shifts in one data bit. A valid transfer holds exactly 24 bits. The first 8 bits are a command code and the last 16 bits are a value. The low three bits of the command pick one of eight channels.

Each channel keeps the most recent value written to it. An eight-bit arrival mask records which channels have been written since the last acknowledge. When the mask fills, all eight values are copied together into a held bank and a set-complete flag rises. The held bank stays fixed until the consumer pulses the acknowledge input. The consumer can therefore read a coherent snapshot of the set while new traffic continues to arrive. Each accepted frame also appears for one cycle on a frame output port. A frame with the wrong length produces a one-cycle error pulse instead.

Top module: `spi_set_collector`

## Requirements
- R1: After reset the arrival mask is 0, set-complete is low, the held bank is all zeros, and neither the frame-valid pulse nor the error pulse is active.
- R2: While select is low, each synchronized rising bit-clock edge samples the data wire, most significant bit first. After exactly 24 edges, the rise of select produces a one-cycle frameValid pulse. In that cycle frameCode holds the first 8 bits received and frameData holds the last 16 bits received.
- R3: An accepted frame writes its value to channel frameCode[2:0] and sets arrival mask bit i for channel i. The upper five command bits do not affect the channel choice.
- R4: A frame with fewer than 24 edges is discarded. It produces a one-cycle frameErr pulse and no frameValid pulse, and it leaves the arrival mask, set-complete and held bank unchanged.
- R5: A frame with more than 24 edges is discarded in the same way as in R4.
- R6: Bit-clock edges that occur while select is high produce no pulse and change no visible state.
- R7: In the cycle in which the arrival mask first reaches 8'hFF, set-complete rises. The held bank then captures the latest value of every channel, with channel i at setValues[16*i+15:16*i].
- R8: While set-complete is high, the held bank does not change, even if further frames arrive.
- R9: A high readAck clears the arrival mask and set-complete at the next clock edge. The held bank keeps its contents until the next complete set.
- R10: A channel written twice before its set completes is captured with its later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdiAsync | input | 1 | Serial data, not synchronized |
| selNAsync | input | 1 | Active-low frame select, not synchronized |
| sckAsync | input | 1 | Serial bit clock, not synchronized |
| readAck | input | 1 | Consumer acknowledge; clears the mask and set-complete |
| frameValid | output | 1 | One-cycle pulse for an accepted frame |
| frameErr | output | 1 | One-cycle pulse for a frame of the wrong length |
| frameCode | output | 8 | Command code of the last accepted frame |
| frameData | output | 16 | Value of the last accepted frame |
| arrivalMask | output | 8 | Channels received since the last acknowledge |
| setComplete | output | 1 | High once all eight channels have been received |
| setValues | output | 128 | Held bank, channel i at bits 16*i+15 down to 16*i |

## Verification
The assertions assume three things about the link. Each level of the bit clock lasts several system clocks. The data wire is stable across the synchronized rising edge. Select changes only while the bit clock is low. With these assumptions, frame pulses are single-cycle events and frozen or cleared state behaves as the requirements state. The bench drives each bit-clock phase for five system clocks and changes data only while the clock is low. It toggles select with the clock idle low. It never pulses readAck during a frame, so every sequence it produces stays inside what the assertions assume.

// File: rtl/spi_set_pkg.sv
package spi_set_pkg;
  parameter int FRAME_BITS = 24;
  parameter int CODE_W     = 8;
  parameter int VAL_W      = 16;
  parameter int NUM_CH     = 8;
  parameter int CH_W       = $clog2(NUM_CH);

  typedef struct packed {
    logic shiftEn;
    logic frameStart;
    logic commit;
    logic frameErr;
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stageQ[0] <= RST_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageQ[s] <= RST_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/spi_set_ctrl.sv
module spi_set_ctrl
  import spi_set_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sckS,
  input  logic         selNS,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(NBITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(NBITS);

  logic             sckPrev, selPrev;
  logic [CNT_W-1:0] bitCount;
  logic             sckRise, selFall, selRise;

  always_comb begin
    sckRise = sckS & ~sckPrev;
    selFall = ~selNS & selPrev;
    selRise = selNS & ~selPrev;
    strobes.shiftEn    = sckRise & ~selNS;
    strobes.frameStart = selFall;
    strobes.commit     = selRise & (bitCount == CNT_GOOD);
    strobes.frameErr   = selRise & (bitCount != CNT_GOOD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      selPrev  <= 1'b1;
      bitCount <= '0;
    end else begin
      sckPrev <= sckS;
      selPrev <= selNS;
      if (selFall)
        bitCount <= strobes.shiftEn ? CNT_W'(1) : '0;
      else if (strobes.shiftEn && bitCount != CNT_MAX)
        bitCount <= bitCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_set_datapath.sv
module spi_set_datapath
  import spi_set_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sdiS,
  input  ctrlStrobes_t            strobes,
  input  logic                    readAck,
  output logic                    frameValid,
  output logic                    frameErr,
  output logic [CODE_W-1:0]       frameCode,
  output logic [VAL_W-1:0]        frameData,
  output logic [NUM_CH-1:0]       arrivalMask,
  output logic                    setComplete,
  output logic [NUM_CH*VAL_W-1:0] setValues
);
  localparam int SR_W = CODE_W + VAL_W;

  logic [SR_W-1:0]         shiftReg;
  logic [VAL_W-1:0]        liveVal [NUM_CH];
  logic [CODE_W-1:0]       inCode;
  logic [VAL_W-1:0]        inData;
  logic [CH_W-1:0]         inCh;
  logic [NUM_CH-1:0]       newBit, maskNext;
  logic                    completeEvt;
  logic [NUM_CH*VAL_W-1:0] mergedVals;

  always_comb begin
    inCode   = shiftReg[SR_W-1 -: CODE_W];
    inData   = shiftReg[VAL_W-1:0];
    inCh     = inCode[CH_W-1:0];
    newBit   = strobes.commit ? (NUM_CH'(1) << inCh) : '0;
    maskNext = (readAck ? '0 : arrivalMask) | newBit;
    completeEvt = strobes.commit & (&maskNext) & ~setComplete;
    for (int i = 0; i < NUM_CH; i++)
      mergedVals[i*VAL_W +: VAL_W] =
        (strobes.commit && inCh == CH_W'(i)) ? inData : liveVal[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[SR_W-2:0], sdiS};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) liveVal[i] <= '0;
    end else if (strobes.commit) begin
      liveVal[inCh] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameValid  <= 1'b0;
      frameErr    <= 1'b0;
      frameCode   <= '0;
      frameData   <= '0;
      arrivalMask <= '0;
      setComplete <= 1'b0;
      setValues   <= '0;
    end else begin
      frameValid  <= strobes.commit;
      frameErr    <= strobes.frameErr;
      if (strobes.commit) begin
        frameCode <= inCode;
        frameData <= inData;
      end
      arrivalMask <= maskNext;
      setComplete <= readAck ? 1'b0 : (setComplete | completeEvt);
      if (completeEvt) setValues <= mergedVals;
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);
  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  p_mask_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    !readAck |=> ((arrivalMask & $past(arrivalMask)) == $past(arrivalMask)));
  p_full_on_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setComplete) |-> (&arrivalMask));
  p_held_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    setComplete |=> $stable(setValues));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    readAck |=> (!setComplete && $countones(arrivalMask) <= 1));
endmodule

// File: rtl/spi_set_collector.sv
module spi_set_collector
  import spi_set_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sdiAsync,
  input  logic                    selNAsync,
  input  logic                    sckAsync,
  input  logic                    readAck,
  output logic                    frameValid,
  output logic                    frameErr,
  output logic [CODE_W-1:0]       frameCode,
  output logic [VAL_W-1:0]        frameData,
  output logic [NUM_CH-1:0]       arrivalMask,
  output logic                    setComplete,
  output logic [NUM_CH*VAL_W-1:0] setValues
);
  logic [2:0]   syncIn, syncOut;
  ctrlStrobes_t strobes;

  assign syncIn = {sckAsync, selNAsync, sdiAsync};

  spi_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(syncIn), .syncOut(syncOut));

  spi_set_ctrl #(.NBITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(syncOut[2]), .selNS(syncOut[1]),
    .strobes(strobes));

  spi_set_datapath u_dp (
    .clk(clk), .rstN(rstN), .sdiS(syncOut[0]), .strobes(strobes),
    .readAck(readAck), .frameValid(frameValid), .frameErr(frameErr),
    .frameCode(frameCode), .frameData(frameData),
    .arrivalMask(arrivalMask), .setComplete(setComplete),
    .setValues(setValues));
endmodule

// File: tb/spi_set_collector_test.sv
module spi_set_collector_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdi = 1'b0, selN = 1'b1, sck = 1'b0, readAck = 1'b0;
  logic frameValid, frameErr, setComplete;
  logic [7:0] frameCode, arrivalMask;
  logic [15:0] frameData;
  logic [127:0] setValues;

  int checks = 0, failures = 0;
  logic [24:0] expQ [$];
  logic [15:0] expLive [8];
  logic [7:0]  expMask = '0;
  logic        expComplete = 1'b0;
  logic [127:0] expHeld = '0;

  spi_set_collector uut (
    .clk(clk), .rstN(rstN), .sdiAsync(sdi), .selNAsync(selN), .sckAsync(sck),
    .readAck(readAck), .frameValid(frameValid), .frameErr(frameErr),
    .frameCode(frameCode), .frameData(frameData), .arrivalMask(arrivalMask),
    .setComplete(setComplete), .setValues(setValues));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: pops one expected item per frame pulse
  always @(negedge clk) begin
    if (rstN && (frameValid || frameErr)) begin
      if (expQ.size() == 0) begin
        chk("R6 unexpected frame pulse", {frameErr, frameValid}, 2'b00);
      end else begin
        logic [24:0] it;
        it = expQ.pop_front();
        if (it[24]) chk("R4/R5 error pulse", {frameErr, frameValid}, 2'b10);
        else chk("R2 frame fields", {frameValid, frameErr, frameCode, frameData},
                 {1'b1, 1'b0, it[23:0]});
      end
    end
  end

  task automatic sendFrame(input logic [7:0] code, input logic [15:0] data, input int nbits);
    logic [23:0] w;
    bit good;
    w = {code, data};
    good = (nbits == 24);
    expQ.push_back({~good, w});
    if (good) begin
      expLive[code[2:0]] = data;
      expMask[code[2:0]] = 1'b1;
      if (&expMask && !expComplete) begin
        expComplete = 1'b1;
        for (int i = 0; i < 8; i++) expHeld[i*16 +: 16] = expLive[i];
      end
    end
    selN = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b0;
      waitCyc(HALF);
      sck = 1'b1;
      waitCyc(HALF);
      sck = 1'b0;
    end
    waitCyc(HALF);
    selN = 1'b1;
    waitCyc(3*HALF);
  endtask

  task automatic checkState(input string tag);
    chk({tag, " mask"}, {120'b0, arrivalMask}, {120'b0, expMask});
    chk({tag, " complete"}, {127'b0, setComplete}, {127'b0, expComplete});
    chk({tag, " held"}, setValues, expHeld);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) expLive[i] = '0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    chk("R1 pulses", {126'b0, frameValid, frameErr}, '0);
    checkState("R1");

    // R2/R3 channels 0..6, upper code bits set to arbitrary values
    for (int c = 0; c < 7; c++) begin
      sendFrame({5'(c * 5 + 3), 3'(c)}, 16'h1000 + 16'(c * 16'h0111), 24);
      checkState("R3");
    end
    // R10 overwrite channel 3 before set completes
    sendFrame(8'hF3, 16'hBEEF, 24);
    checkState("R10");
    // R4 short frame for channel 7
    sendFrame(8'h07, 16'h7777, 16);
    checkState("R4");
    // R5 long frame for channel 7
    sendFrame(8'h07, 16'h7777, 25);
    checkState("R5");
    // R6 bit-clock activity while select is high
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      waitCyc(HALF); sck = 1'b1; waitCyc(HALF); sck = 1'b0;
    end
    waitCyc(3*HALF);
    checkState("R6");
    // R7 completing frame
    sendFrame(8'h27, 16'hC0DE, 24);
    checkState("R7");
    chk("R7 ch3 later value R10", {112'b0, setValues[63:48]}, {112'b0, 16'hBEEF});
    // R8 frame while complete: held bank frozen
    sendFrame(8'h01, 16'h5A5A, 24);
    checkState("R8");
    // R9 acknowledge
    @(negedge clk); readAck = 1'b1;
    @(negedge clk); readAck = 1'b0;
    expMask = '0; expComplete = 1'b0;
    checkState("R9");
    // second round, reverse channel order
    for (int c = 7; c >= 0; c--)
      sendFrame({5'(31 - c), 3'(c)}, 16'h9000 ^ 16'(c * 16'h1357), 24);
    checkState("R7 second set");
    waitCyc(5);
    chk("R2 scoreboard drained", 128'(expQ.size()), '0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule